// File: doc/BRIEF.md
# Oversampling Serial Receiver with Error Flags

This block receives asynchronous frames of one start bit, eight data bits and one stop bit, with no parity. A baud generator outside the block supplies `tick16`, an enable that pulses sixteen times per bit period. On each tick the receiver samples `rxd`. It resolves every bit from that bit's 8th, 9th and 10th samples, counted from the tick that saw the falling edge, which is sample 1. Complete bytes go to a holding register that software reads. The same register interface shows a data-full flag and three error flags: overrun, noise and framing.

The frame engine is a four-state machine:
- **IDLE**: watches for a high-to-low change on `rxd` between two consecutive ticks. When it sees one, it moves to START (transition *edge_seen*).
- **START**: collects the middle samples. If they are not all low, it returns to IDLE (*start_rejected*). After the 16th tick it moves to DATA (*start_accepted*).
- **DATA**: shifts in eight bits, LSB first. After the eighth bit it moves to STOP (*byte_complete*).
- **STOP**: at its 10th sample it hands the frame to the flag bank and returns to IDLE (*frame_end*).

A rejected start whose samples are mixed leaves a noise mark that software cannot see. That mark appears in the noise flag of the next frame that is accepted. Error flags follow a two-step clear: software reads status, then reads data. The receive interrupt is a single-cycle pulse.

Top module: `serial_rx_os16`

## Requirements
- R1: In IDLE, a tick where `rxd` is 0 and the previous tick's sample was 1 starts a frame. That tick is sample 1. The start is accepted only if samples 8, 9 and 10 are all 0.
- R2: A start whose samples 8–10 are not all 0 is discarded, and `rdfull` stays unchanged. The pattern 111 discards silently and leaves no noise mark. After a discard, a new frame needs a fresh 1-to-0 change between ticks.
- R3: Each data bit is the majority of its samples 8, 9 and 10. Bits fill `rx_data` LSB first.
- R4: If samples 8–10 of any data bit or of the stop bit disagree, `err_noise` is set together with `rdfull` for that frame.
- R5: A discarded start with mixed samples (any pattern with both 0 and 1) sets a hidden mark. That mark sets `err_noise` when the next frame is stored, and is then consumed.
- R6: A stop bit whose majority is 0 sets `err_frame`. The byte is still stored and `rdfull` is set.
- R7: A frame that ends while `rdfull` is 1 sets `err_ovr`. `rx_data` keeps the older byte, and the new frame's noise and framing results are dropped.
- R8: A `data_rd` pulse clears `rdfull` on the next clock.
- R9: On `data_rd`, each error flag clears only if a `stat_rd` pulse came in an earlier cycle while that flag was set. A `stat_rd` pulse alone changes no flag.
- R10: `irq` is a one-cycle pulse when a frame ends (stored or overrun), provided `rx_ie` is 1 and `irq_mask` is 0. It is sampled at the frame-end tick.
- R11: After reset, `rx_data` is 0 and every flag and `irq` is 0.
- R12: Flags, data and `irq` update on the clock edge of the tick that carries sample 10 of the stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Sample enable, 16 per bit time |
| rxd | input | 1 | Serial line, already synchronous to clk |
| stat_rd | input | 1 | Status register read strobe |
| data_rd | input | 1 | Data register read strobe |
| rx_ie | input | 1 | Receive interrupt enable |
| irq_mask | input | 1 | Global interrupt mask (1 blocks) |
| rx_data | output | 8 | Received data register |
| rdfull | output | 1 | Data register full |
| err_ovr | output | 1 | Overrun flag |
| err_noise | output | 1 | Noise flag |
| err_frame | output | 1 | Framing error flag |
| irq | output | 1 | Receive interrupt pulse |

## Verification
The assertions assume that `rxd` is already synchronous. They also assume that `tick16` is the only thing that moves the frame engine, so flags can change only on a tick or a data read. The one-cycle `irq` property further assumes that frame ends are at least two clocks apart.

The stimulus holds `rxd` steady across each four-clock tick period, with exactly one tick per period. It places read strobes in the first clock of a period, never on a tick clock. That way, a read never coincides with a frame end.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
    typedef enum logic [1:0] {
        RXS_IDLE  = 2'd0,
        RXS_START = 2'd1,
        RXS_DATA  = 2'd2,
        RXS_STOP  = 2'd3
    } rxs_t;
endpackage

// File: rtl/rx_vote3.sv
module rx_vote3 (
    input  logic s_a,
    input  logic s_b,
    input  logic s_c,
    output logic maj,
    output logic mixed
);
    always_comb begin
        maj   = (s_a & s_b) | (s_a & s_c) | (s_b & s_c);
        mixed = (s_a ^ s_b) | (s_b ^ s_c);
    end
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import uart_rx_pkg::*;
#(
    parameter int OSR     = 16,
    parameter int DATA_W  = 8,
    parameter int SMP_MID = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd,
    output logic              frame_done,
    output logic [DATA_W-1:0] frame_byte,
    output logic              frame_noise,
    output logic              frame_ferr,
    output logic              false_start_noisy
);
    localparam int CW = $clog2(OSR + 1);
    localparam int IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CW-1:0] S_LO  = CW'(SMP_MID - 1);
    localparam logic [CW-1:0] S_MD  = CW'(SMP_MID);
    localparam logic [CW-1:0] S_HI  = CW'(SMP_MID + 1);
    localparam logic [CW-1:0] S_END = CW'(OSR);
    localparam logic [IW-1:0] LAST_BIT = IW'(DATA_W - 1);

    rxs_t              state, state_n;
    logic [CW-1:0]     cnt;
    logic              smp_a, smp_b;
    logic [DATA_W-1:0] shreg;
    logic [IW-1:0]     bit_idx;
    logic              noise_acc;
    logic              line_prev;
    logic              maj, mixed;
    logic              mid_tick, end_tick, start_ok;

    rx_vote3 vote_i (
        .s_a   (smp_a),
        .s_b   (smp_b),
        .s_c   (rxd),
        .maj   (maj),
        .mixed (mixed)
    );

    assign mid_tick = tick && (cnt == S_HI);
    assign end_tick = tick && (cnt == S_END);
    assign start_ok = !smp_a && !smp_b && !rxd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RXS_IDLE;
        else        state <= state_n;
    end

    always_comb begin
        state_n = state;
        unique case (state)
            RXS_IDLE:  if (tick && line_prev && !rxd) state_n = RXS_START;
            RXS_START: begin
                if (mid_tick && !start_ok)  state_n = RXS_IDLE;
                else if (end_tick)          state_n = RXS_DATA;
            end
            RXS_DATA:  if (end_tick && bit_idx == LAST_BIT) state_n = RXS_STOP;
            RXS_STOP:  if (mid_tick) state_n = RXS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            smp_a     <= 1'b1;
            smp_b     <= 1'b1;
            shreg     <= '0;
            bit_idx   <= '0;
            noise_acc <= 1'b0;
            line_prev <= 1'b1;
        end else if (tick) begin
            if (state == RXS_IDLE) begin
                line_prev <= rxd;
                cnt       <= CW'(2);
                bit_idx   <= '0;
                noise_acc <= 1'b0;
            end else begin
                cnt <= (cnt == S_END) ? CW'(1) : cnt + 1'b1;
                if (cnt == S_LO) smp_a <= rxd;
                if (cnt == S_MD) smp_b <= rxd;
                if (state == RXS_DATA && cnt == S_HI) begin
                    shreg     <= {maj, shreg[DATA_W-1:1]};
                    noise_acc <= noise_acc | mixed;
                end
                if (state == RXS_DATA && cnt == S_END) bit_idx <= bit_idx + 1'b1;
                if ((state == RXS_START || state == RXS_STOP) && cnt == S_HI)
                    line_prev <= rxd;
            end
        end
    end

    always_comb begin
        frame_done        = (state == RXS_STOP) && mid_tick;
        frame_byte        = shreg;
        frame_noise       = noise_acc | mixed;
        frame_ferr        = !maj;
        false_start_noisy = (state == RXS_START) && mid_tick && mixed;
    end
endmodule

// File: rtl/rx_flag_bank.sv
module rx_flag_bank #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_done,
    input  logic [DATA_W-1:0] frame_byte,
    input  logic              frame_noise,
    input  logic              frame_ferr,
    input  logic              false_start_noisy,
    input  logic              stat_rd,
    input  logic              data_rd,
    input  logic              rx_ie,
    input  logic              irq_mask,
    output logic [DATA_W-1:0] rx_data,
    output logic              rdfull,
    output logic              err_ovr,
    output logic              err_noise,
    output logic              err_frame,
    output logic              irq
);
    logic              arm_ovr, arm_nf, arm_fe, hid_nf;
    logic [DATA_W-1:0] d_n;
    logic full_n, ovr_n, nf_n, fe_n, irq_n;
    logic arm_ovr_n, arm_nf_n, arm_fe_n, hid_n;

    always_comb begin
        d_n = rx_data;   full_n = rdfull;
        ovr_n = err_ovr; nf_n = err_noise; fe_n = err_frame;
        arm_ovr_n = arm_ovr; arm_nf_n = arm_nf; arm_fe_n = arm_fe;
        hid_n = hid_nf;
        if (stat_rd) begin
            arm_ovr_n = arm_ovr | err_ovr;
            arm_nf_n  = arm_nf  | err_noise;
            arm_fe_n  = arm_fe  | err_frame;
        end
        if (data_rd) begin
            full_n = 1'b0;
            if (arm_ovr) begin ovr_n = 1'b0; arm_ovr_n = 1'b0; end
            if (arm_nf)  begin nf_n  = 1'b0; arm_nf_n  = 1'b0; end
            if (arm_fe)  begin fe_n  = 1'b0; arm_fe_n  = 1'b0; end
        end
        if (false_start_noisy) hid_n = 1'b1;
        if (frame_done) begin
            if (!full_n) begin
                d_n    = frame_byte;
                full_n = 1'b1;
                hid_n  = 1'b0;
                if (frame_noise || hid_nf) begin nf_n = 1'b1; arm_nf_n = 1'b0; end
                if (frame_ferr)            begin fe_n = 1'b1; arm_fe_n = 1'b0; end
            end else begin
                ovr_n     = 1'b1;
                arm_ovr_n = 1'b0;
            end
        end
        irq_n = frame_done && rx_ie && !irq_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data <= '0; rdfull <= 1'b0; err_ovr <= 1'b0;
            err_noise <= 1'b0; err_frame <= 1'b0; irq <= 1'b0;
            arm_ovr <= 1'b0; arm_nf <= 1'b0; arm_fe <= 1'b0; hid_nf <= 1'b0;
        end else begin
            rx_data <= d_n; rdfull <= full_n; err_ovr <= ovr_n;
            err_noise <= nf_n; err_frame <= fe_n; irq <= irq_n;
            arm_ovr <= arm_ovr_n; arm_nf <= arm_nf_n; arm_fe <= arm_fe_n;
            hid_nf <= hid_n;
        end
    end
endmodule

// File: rtl/serial_rx_os16.sv
module serial_rx_os16 #(
    parameter int OSR     = 16,
    parameter int DATA_W  = 8,
    parameter int SMP_MID = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              rxd,
    input  logic              stat_rd,
    input  logic              data_rd,
    input  logic              rx_ie,
    input  logic              irq_mask,
    output logic [DATA_W-1:0] rx_data,
    output logic              rdfull,
    output logic              err_ovr,
    output logic              err_noise,
    output logic              err_frame,
    output logic              irq
);
    logic              f_done, f_noise, f_ferr, f_false;
    logic [DATA_W-1:0] f_byte;

    rx_frame_fsm #(.OSR(OSR), .DATA_W(DATA_W), .SMP_MID(SMP_MID)) fsm_i (
        .clk               (clk),
        .rst_n             (rst_n),
        .tick              (tick16),
        .rxd               (rxd),
        .frame_done        (f_done),
        .frame_byte        (f_byte),
        .frame_noise       (f_noise),
        .frame_ferr        (f_ferr),
        .false_start_noisy (f_false)
    );

    rx_flag_bank #(.DATA_W(DATA_W)) flags_i (
        .clk               (clk),
        .rst_n             (rst_n),
        .frame_done        (f_done),
        .frame_byte        (f_byte),
        .frame_noise       (f_noise),
        .frame_ferr        (f_ferr),
        .false_start_noisy (f_false),
        .stat_rd           (stat_rd),
        .data_rd           (data_rd),
        .rx_ie             (rx_ie),
        .irq_mask          (irq_mask),
        .rx_data           (rx_data),
        .rdfull            (rdfull),
        .err_ovr           (err_ovr),
        .err_noise         (err_noise),
        .err_frame         (err_frame),
        .irq               (irq)
    );
endmodule

// File: rtl/serial_rx_os16_chk.sv
module serial_rx_os16_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick16,
    input logic              data_rd,
    input logic              rx_ie,
    input logic              irq_mask,
    input logic [DATA_W-1:0] rx_data,
    input logic              rdfull,
    input logic              err_ovr,
    input logic              err_noise,
    input logic              err_frame,
    input logic              irq
);
    p_irq_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(rx_ie) && !$past(irq_mask)));
    p_irq_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (rdfull || err_ovr));
    p_keep_on_ovr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_ovr) |-> $stable(rx_data));
    p_nf_with_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_noise) |-> rdfull);
    p_fe_with_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_frame) |-> rdfull);
    p_read_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !tick16) |=> !rdfull);
    p_flags_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick16 && !data_rd) |=> $stable({rdfull, err_noise, err_frame, err_ovr, rx_data}));
endmodule

bind serial_rx_os16 serial_rx_os16_chk #(.DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick16    (tick16),
    .data_rd   (data_rd),
    .rx_ie     (rx_ie),
    .irq_mask  (irq_mask),
    .rx_data   (rx_data),
    .rdfull    (rdfull),
    .err_ovr   (err_ovr),
    .err_noise (err_noise),
    .err_frame (err_frame),
    .irq       (irq)
);

// File: tb/serial_rx_os16_tb_top.sv
module serial_rx_os16_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick16 = 1'b0, rxd = 1'b1, stat_rd = 1'b0, data_rd = 1'b0;
    logic rx_ie = 1'b1, irq_mask = 1'b0;
    logic [7:0] rx_data;
    logic rdfull, err_ovr, err_noise, err_frame, irq;
    int tests = 0, fails = 0, irq_seen = 0;

    always #10 clk = ~clk;

    serial_rx_os16 dut_i (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
        .stat_rd(stat_rd), .data_rd(data_rd), .rx_ie(rx_ie), .irq_mask(irq_mask),
        .rx_data(rx_data), .rdfull(rdfull), .err_ovr(err_ovr),
        .err_noise(err_noise), .err_frame(err_frame), .irq(irq)
    );

    // behavioural reference model
    logic [7:0] m_data, m_byte;
    logic m_full, m_ovr, m_nf, m_fe, m_irq, m_hid;
    logic a_ovr, a_nf, a_fe;
    int   m_mode, m_pos, m_prev, m_s8, m_s9, m_noise;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_data = 0; m_full = 0; m_ovr = 0; m_nf = 0; m_fe = 0; m_irq = 0; m_hid = 0;
            a_ovr = 0; a_nf = 0; a_fe = 0; m_mode = 0; m_pos = 0; m_prev = 1;
            m_s8 = 1; m_s9 = 1; m_noise = 0; m_byte = 0;
        end else begin
            logic o_ovr, o_nf, o_fe;
            o_ovr = a_ovr; o_nf = a_nf; o_fe = a_fe;
            m_irq = 0;
            if (stat_rd) begin a_ovr |= m_ovr; a_nf |= m_nf; a_fe |= m_fe; end
            if (data_rd) begin
                m_full = 0;
                if (o_ovr) begin m_ovr = 0; a_ovr = 0; end
                if (o_nf)  begin m_nf = 0;  a_nf = 0;  end
                if (o_fe)  begin m_fe = 0;  a_fe = 0;  end
            end
            if (tick16) begin
                if (m_mode == 0) begin
                    if (m_prev == 1 && rxd == 0) begin m_mode = 1; m_pos = 1; m_noise = 0; end
                    m_prev = int'(rxd);
                end else begin
                    int smp, bn, v;
                    m_pos++;
                    smp = (m_pos - 1) % 16 + 1;
                    bn  = (m_pos - 1) / 16;
                    if (smp == 8) m_s8 = int'(rxd);
                    if (smp == 9) m_s9 = int'(rxd);
                    if (smp == 10) begin
                        v = m_s8 + m_s9 + int'(rxd);
                        if (bn == 0) begin
                            if (v != 0) begin
                                m_mode = 0; m_prev = int'(rxd);
                                if (v == 1 || v == 2) m_hid = 1;
                            end
                        end else if (bn <= 8) begin
                            m_byte[bn-1] = (v >= 2);
                            if (v == 1 || v == 2) m_noise = 1;
                        end else begin
                            m_mode = 0; m_prev = int'(rxd);
                            if (v == 1 || v == 2) m_noise = 1;
                            m_irq = rx_ie && !irq_mask;
                            if (!m_full) begin
                                m_data = m_byte; m_full = 1;
                                if (m_noise != 0 || m_hid) begin m_nf = 1; a_nf = 0; end
                                if (v < 2) begin m_fe = 1; a_fe = 0; end
                                m_hid = 0;
                            end else begin
                                m_ovr = 1; a_ovr = 0;
                            end
                        end
                    end
                end
            end
        end
    end

    // per-clock comparison, sampled away from the active edge (R12 timing)
    always @(negedge clk) begin
        if (rst_n) begin
            tests++;
            if (irq) irq_seen++;
            if (rx_data !== m_data) begin fails++; $display("FAIL R3/R12 rx_data act %0h exp %0h", rx_data, m_data); end
            if (rdfull !== m_full)  begin fails++; $display("FAIL R12 rdfull act %0d exp %0d", rdfull, m_full); end
            if (err_noise !== m_nf) begin fails++; $display("FAIL R4 err_noise act %0d exp %0d", err_noise, m_nf); end
            if (err_frame !== m_fe) begin fails++; $display("FAIL R6 err_frame act %0d exp %0d", err_frame, m_fe); end
            if (err_ovr !== m_ovr)  begin fails++; $display("FAIL R7 err_ovr act %0d exp %0d", err_ovr, m_ovr); end
            if (irq !== m_irq)      begin fails++; $display("FAIL R10 irq act %0d exp %0d", irq, m_irq); end
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin fails++; $display("FAIL %s act %0h exp %0h", req, act, exp); end
    endtask

    // one tick period: read strobes in clock 1, tick in clock 3
    task automatic put(input logic v, input logic sr, input logic dr);
        rxd = v; stat_rd = sr; data_rd = dr;
        @(negedge clk); stat_rd = 0; data_rd = 0;
        @(negedge clk); tick16 = 1;
        @(negedge clk); tick16 = 0;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) put(1'b1, 1'b0, 1'b0);
    endtask

    task automatic send_frame(input logic [7:0] d, input int gbit, input logic stop_lvl);
        for (int b = 0; b < 10; b++)
            for (int s = 1; s <= 16; s++) begin
                logic v;
                v = (b == 0) ? 1'b0 : (b == 9) ? stop_lvl : d[b-1];
                if (b == gbit && s == 9) v = ~v;
                put(v, 1'b0, 1'b0);
            end
        idle(3);
    endtask

    task automatic clear_all();
        put(1'b1, 1'b1, 1'b0);
        put(1'b1, 1'b0, 1'b1);
    endtask

    initial begin
        int irq0;
        repeat (3) @(negedge clk);
        chk(rdfull == 0 && err_noise == 0 && err_frame == 0 && err_ovr == 0 && irq == 0 && rx_data == 0,
            "R11 reset", {rdfull, err_noise, err_frame, err_ovr}, 0);
        rst_n = 1;
        idle(4);

        irq0 = irq_seen;
        send_frame(8'hA5, -1, 1'b1);
        chk(rdfull == 1, "R1 start accepted", rdfull, 1);
        chk(rx_data == 8'hA5, "R3 byte", rx_data, 8'hA5);
        chk(irq_seen == irq0 + 1, "R10 irq pulse", irq_seen - irq0, 1);
        put(1'b1, 1'b0, 1'b1);
        chk(rdfull == 0, "R8 data read empties", rdfull, 0);

        send_frame(8'h5A, 4, 1'b1);
        chk(err_noise == 1, "R4 data-bit noise", err_noise, 1);
        chk(rx_data == 8'h5A, "R3 majority byte", rx_data, 8'h5A);
        put(1'b1, 1'b0, 1'b1);
        chk(rdfull == 0 && err_noise == 1, "R9 no status read keeps flag", err_noise, 1);
        clear_all();
        chk(err_noise == 0, "R9 status then data clears", err_noise, 0);

        for (int i = 0; i < 9; i++) put(1'b0, 1'b0, 1'b0);
        idle(20);
        chk(rdfull == 0 && err_noise == 0, "R2 false start discarded", rdfull, 0);
        send_frame(8'h3C, -1, 1'b1);
        chk(err_noise == 1 && rx_data == 8'h3C, "R5 hidden noise reported", err_noise, 1);
        clear_all();

        put(1'b0, 1'b0, 1'b0);
        idle(20);
        chk(rdfull == 0, "R2 short glitch discarded", rdfull, 0);
        send_frame(8'h0F, -1, 1'b1);
        chk(err_noise == 0 && rx_data == 8'h0F, "R2 silent discard leaves no noise", err_noise, 0);
        put(1'b1, 1'b0, 1'b1);

        send_frame(8'hC3, -1, 1'b0);
        idle(20);
        chk(err_frame == 1 && rx_data == 8'hC3 && rdfull == 1, "R6 framing", err_frame, 1);
        clear_all();
        chk(err_frame == 0, "R9 framing cleared", err_frame, 0);

        send_frame(8'h81, 9, 1'b1);
        chk(err_noise == 1 && err_frame == 0, "R4 stop-bit noise", err_noise, 1);
        clear_all();

        irq_mask = 1;
        irq0 = irq_seen;
        send_frame(8'h11, -1, 1'b1);
        send_frame(8'h22, 3, 1'b1);
        chk(err_ovr == 1 && rx_data == 8'h11, "R7 overrun keeps byte", rx_data, 8'h11);
        chk(err_noise == 0, "R7 overrun drops new noise", err_noise, 0);
        chk(irq_seen == irq0, "R10 masked irq", irq_seen - irq0, 0);
        clear_all();
        chk(err_ovr == 0 && rdfull == 0, "R9 overrun cleared", err_ovr, 0);
        idle(4);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog act timeout exp finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule